// File: doc/BRIEF.md
# Configuration Packet Stream Parser

The parser takes configuration data one byte at a time. While it is hunting, it slides a four-byte window over the input, one byte at a time, and waits for the synchronization pattern 0xAA995566. Everything before that pattern is thrown away. Once it has found the pattern, it groups the bytes that follow into 32-bit words. The first byte received of each group becomes the most significant byte of the word.

After synchronization, each word is either a packet header or a payload word. A Type 1 header names a target register and gives a count of up to 2047 words. A Type 2 header carries no register field. It reuses the register named by the Type 1 header just before it, and widens the count to 27 bits. Each payload word of a write leaves the block as a single-cycle write strobe together with its register address and data. No-operation and read headers are consumed and produce nothing. Malformed headers raise a one-cycle error pulse. A write of the desynchronize code to the command register sends the parser back to hunting.

Top module: `cfg_pkt_parser`

## Requirements
- R1: While reset is held, `in_ready` is low. After reset is released, `in_ready` goes high and stays high. Each byte is accepted when `in_valid` and `in_ready` are both high. After synchronization, every four accepted bytes form one word, with the first byte placed in bits 31:24.
- R2: In the hunt state, no write strobe is produced, whatever bytes arrive. The sync pattern 0xAA995566 is recognised at any byte offset. The byte that follows the pattern is the first byte of the first header.
- R3: A header is Type 1 when bits 31:29 = 001. A Type 1 header with opcode bits 28:27 = 10 (write) latches the register address from bits 17:13 and the count from bits 10:0. Each of the next `count` words is then output on `wr_data`, with `wr_valid` high and `wr_addr` set to the latched address. The strobe appears one clock after the fourth byte of the word is accepted.
- R4: A header is Type 2 when bits 31:29 = 010. A Type 2 write that directly follows a Type 1 header takes its count from bits 26:0, and its payload goes to the address latched by that Type 1 header. A Type 1 header is still the previous header after its own payload words have passed.
- R5: A Type 2 header that does not directly follow a Type 1 read or write header produces a one-cycle `pkt_err` pulse. The header is then dropped, and the next word is treated as a header. The same applies after synchronization, before any header has been seen.
- R6: A header with opcode 00 (no-op) produces no strobe and no error, and it ends Type 1 adjacency. A header with opcode 01 (read) is consumed with no strobe; on a Type 1 read header, the address is still latched.
- R7: A write header whose count is zero has no payload. The next word is treated as a header.
- R8: `pkt_err` pulses for one cycle when a header has a type other than 001 or 010, or has opcode 11. `pkt_err` and `wr_valid` are never high together.
- R9: A payload word written to register 4 with the value 0x0000000D is output and then returns the parser to hunting. Any words left in that packet and all following words produce nothing until the sync pattern is seen again.
- R10: During and right after reset, `wr_valid` and `pkt_err` are low and the parser is hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Configuration byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_ready | output | 1 | Parser accepts a byte this cycle |
| wr_valid | output | 1 | One-cycle register write strobe |
| wr_addr | output | 5 | Register address of the write |
| wr_data | output | 32 | Data word of the write |
| pkt_err | output | 1 | One-cycle malformed-header pulse |

## Verification
The bench feeds the parser streams with idle gaps of random length, and checks its outputs on every clock against a reference model written at byte level. Before synchronization, the stream contains a partial sync pattern and a word that looks like a header; a parser that hunted on word boundaries, or decoded before sync, would miss the misaligned pattern or emit a write. Further streams exercise:
- a Type 2 write after a zero-count Type 1 header;
- a Type 2 write after a Type 1 header whose payload has already passed;
- a Type 2 write after a no-op header.

A parser that tracked adjacency wrongly would either raise a false error or write to a stale address. A desynchronize write in the middle of a packet is followed by leftover payload words and by headers; a parser that kept decoding after desync would emit writes that the model does not expect.

// File: rtl/cfg_pkt_pkg.sv
package cfg_pkt_pkg;

  localparam int WORD_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int BYTES_PW = WORD_W / BYTE_W;

  // header field layout
  localparam int TYPE_LSB = 29;
  localparam int OP_LSB   = 27;
  localparam int ADDR_LSB = 13;
  localparam int ADDR_W   = 5;
  localparam int T1_CW    = 11;
  localparam int T2_CW    = 27;

  localparam logic [2:0] HT_TYPE1 = 3'b001;
  localparam logic [2:0] HT_TYPE2 = 3'b010;

  localparam logic [1:0] OP_NOP = 2'b00;
  localparam logic [1:0] OP_WR  = 2'b10;
  localparam logic [1:0] OP_RSV = 2'b11;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_HDR  = 2'd1,
    ST_PAY  = 2'd2
  } pstate_e;

endpackage

// File: rtl/cfg_word_asm.sv
module cfg_word_asm #(
  parameter int BYTE_W = 8,
  parameter int BYTES  = 4,
  localparam int WORD_W = BYTE_W * BYTES,
  localparam int CW     = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              byte_vld,
  input  logic              align,
  output logic [WORD_W-1:0] word_next,
  output logic              byte_stb,
  output logic              word_stb
);

  localparam logic [CW-1:0] LAST = CW'(BYTES - 1);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CW-1:0]     cnt_q, cnt_d;

  assign word_next = {sh_q[WORD_W-BYTE_W-1:0], byte_in};
  assign byte_stb  = byte_vld;
  assign word_stb  = byte_vld && (cnt_q == LAST);

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (byte_vld) begin
      sh_d = word_next;
      if (align || cnt_q == LAST) cnt_d = '0;
      else                        cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (byte_vld) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  AST_WORD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |=> !word_stb) else $error("word strobes too close");  // R1

endmodule

// File: rtl/cfg_pkt_fsm.sv
module cfg_pkt_fsm
  import cfg_pkt_pkg::*;
#(
  parameter logic [WORD_W-1:0] SYNC_WORD   = 32'hAA99_5566,
  parameter logic [ADDR_W-1:0] CMD_ADDR    = 5'd4,
  parameter logic [WORD_W-1:0] DESYNC_CODE = 32'h0000_000D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb,
  input  logic              word_stb,
  input  logic [WORD_W-1:0] word_next,
  output logic              align,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [WORD_W-1:0] out_data,
  output logic              out_err
);

  pstate_e           state_q, state_d;
  logic [T2_CW-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              prev_q, prev_d;
  logic              ld_out, err_d;
  logic              ov_q, er_q;
  logic [ADDR_W-1:0] oa_q;
  logic [WORD_W-1:0] od_q;

  logic [2:0]        hdr_type;
  logic [1:0]        hdr_op;
  logic [ADDR_W-1:0] hdr_addr;
  logic [T1_CW-1:0]  t1_cnt;
  logic [T2_CW-1:0]  t2_cnt;

  assign hdr_type = word_next[TYPE_LSB +: 3];
  assign hdr_op   = word_next[OP_LSB +: 2];
  assign hdr_addr = word_next[ADDR_LSB +: ADDR_W];
  assign t1_cnt   = word_next[T1_CW-1:0];
  assign t2_cnt   = word_next[T2_CW-1:0];

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    addr_d  = addr_q;
    prev_d  = prev_q;
    align   = 1'b0;
    ld_out  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_HUNT: begin
        if (byte_stb && word_next == SYNC_WORD) begin
          state_d = ST_HDR;
          align   = 1'b1;
          prev_d  = 1'b0;
        end
      end
      ST_HDR: begin
        if (word_stb) begin
          prev_d = 1'b0;
          if (hdr_type == HT_TYPE1) begin
            if (hdr_op == OP_RSV) begin
              err_d = 1'b1;
            end else if (hdr_op != OP_NOP) begin
              addr_d = hdr_addr;
              prev_d = 1'b1;
              if (hdr_op == OP_WR && t1_cnt != '0) begin
                cnt_d   = {{(T2_CW-T1_CW){1'b0}}, t1_cnt};
                state_d = ST_PAY;
              end
            end
          end else if (hdr_type == HT_TYPE2) begin
            if (!prev_q || hdr_op == OP_RSV) begin
              err_d = 1'b1;
            end else if (hdr_op == OP_WR && t2_cnt != '0) begin
              cnt_d   = t2_cnt;
              state_d = ST_PAY;
            end
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_PAY: begin
        if (word_stb) begin
          ld_out = 1'b1;
          cnt_d  = cnt_q - T2_CW'(1);
          if (addr_q == CMD_ADDR && word_next == DESYNC_CODE) state_d = ST_HUNT;
          else if (cnt_q == T2_CW'(1))                        state_d = ST_HDR;
        end
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
      addr_q  <= '0;
      prev_q  <= 1'b0;
      ov_q    <= 1'b0;
      er_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      addr_q  <= addr_d;
      prev_q  <= prev_d;
      ov_q    <= ld_out;
      er_q    <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oa_q <= '0;
      od_q <= '0;
    end else if (ld_out) begin
      oa_q <= addr_q;
      od_q <= word_next;
    end
  end

  assign out_valid = ov_q;
  assign out_addr  = oa_q;
  assign out_data  = od_q;
  assign out_err   = er_q;

  AST_HUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HUNT && $past(state_q) == ST_HUNT) |-> !out_valid) else $error("write while hunting");  // R2
  AST_OUT_FROM_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(state_q) == ST_PAY) else $error("write not from payload");  // R3
  AST_T2_ORPHAN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HDR && word_stb && hdr_type == HT_TYPE2 && !prev_q) |=> out_err) else $error("orphan type 2 not flagged");  // R5
  AST_PAY_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_PAY |-> cnt_q != '0) else $error("payload with zero count");  // R7
  AST_ERR_NOT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_err)) else $error("error and write together");  // R8
  AST_DESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAY && word_stb && addr_q == CMD_ADDR && word_next == DESYNC_CODE)
      |=> state_q == ST_HUNT) else $error("desync ignored");  // R9

endmodule

// File: rtl/cfg_pkt_parser.sv
module cfg_pkt_parser
  import cfg_pkt_pkg::*;
#(
  parameter logic [WORD_W-1:0] SYNC_WORD   = 32'hAA99_5566,
  parameter logic [ADDR_W-1:0] CMD_ADDR    = 5'd4,
  parameter logic [WORD_W-1:0] DESYNC_CODE = 32'h0000_000D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              pkt_err
);

  logic              rs_meta_q, rs_q;
  logic              byte_vld, byte_stb, word_stb, align;
  logic [WORD_W-1:0] word_next;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_q      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_q      <= rs_meta_q;
    end
  end

  assign in_ready = rs_q;
  assign byte_vld = in_valid && in_ready;

  cfg_word_asm #(.BYTE_W(BYTE_W), .BYTES(BYTES_PW)) i_asm (
    .clk       (clk),
    .rst_n     (rs_q),
    .byte_in   (in_data),
    .byte_vld  (byte_vld),
    .align     (align),
    .word_next (word_next),
    .byte_stb  (byte_stb),
    .word_stb  (word_stb)
  );

  cfg_pkt_fsm #(
    .SYNC_WORD   (SYNC_WORD),
    .CMD_ADDR    (CMD_ADDR),
    .DESYNC_CODE (DESYNC_CODE)
  ) i_fsm (
    .clk       (clk),
    .rst_n     (rs_q),
    .byte_stb  (byte_stb),
    .word_stb  (word_stb),
    .word_next (word_next),
    .align     (align),
    .out_valid (wr_valid),
    .out_addr  (wr_addr),
    .out_data  (wr_data),
    .out_err   (pkt_err)
  );

endmodule

// File: tb/test_cfg_pkt_parser.sv
`timescale 1ns/1ps
module test_cfg_pkt_parser;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  in_data;
  logic        in_valid;
  logic        in_ready;
  logic        wr_valid;
  logic [4:0]  wr_addr;
  logic [31:0] wr_data;
  logic        pkt_err;

  always #10 clk = ~clk;

  cfg_pkt_parser i_cfg_pkt_parser (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .pkt_err(pkt_err)
  );

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  int    seen_wr = 0;
  string tag = "R10";

  // reference model state
  logic [31:0] m_sh = '0;
  int          m_st = 0;      // 0 hunt, 1 header, 2 payload
  int          m_bc = 0;
  int          m_cnt = 0;
  int          m_addr = 0;
  bit          m_prev = 0;
  bit          exp_v = 0, exp_e = 0;
  logic [4:0]  exp_a = '0;
  logic [31:0] exp_d = '0;

  logic [7:0]  bq[$];

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic chk(input string t, input bit ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act %h exp %h", t, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog expired act %0d exp below 100000", cyc);
        summary();
        $finish;
      end
    end
  end

  task automatic model_byte(input logic [7:0] b);
    logic [31:0] w;
    int typ, op;
    w = {m_sh[23:0], b};
    m_sh = w;
    if (m_st == 0) begin
      if (w == 32'hAA995566) begin m_st = 1; m_bc = 0; m_prev = 0; end
      return;
    end
    m_bc++;
    if (m_bc < 4) return;
    m_bc = 0;
    if (m_st == 2) begin
      exp_v = 1; exp_a = m_addr[4:0]; exp_d = w;
      m_cnt--;
      if (m_addr == 4 && w == 32'h0000000D) m_st = 0;
      else if (m_cnt == 0) m_st = 1;
      return;
    end
    typ = int'(w >> 29);
    op  = int'((w >> 27) & 3);
    if (typ == 1) begin
      if (op == 3) begin exp_e = 1; m_prev = 0; end
      else if (op == 0) m_prev = 0;
      else begin
        m_addr = int'((w >> 13) & 31);
        m_prev = 1;
        if (op == 2 && (w & 32'h7FF) != 0) begin m_cnt = int'(w & 32'h7FF); m_st = 2; end
      end
    end else if (typ == 2) begin
      if (!m_prev || op == 3) exp_e = 1;
      else if (op == 2 && (w & 32'h07FF_FFFF) != 0) begin
        m_cnt = int'(w & 32'h07FF_FFFF); m_st = 2;
      end
      m_prev = 0;
    end else begin
      exp_e = 1; m_prev = 0;
    end
  endtask

  // one clock: compare what the previous drive predicted, then drive
  task automatic tick(input bit v, input logic [7:0] b);
    bit ok;
    @(negedge clk);
    ok = (wr_valid === exp_v) && (pkt_err === exp_e) &&
         (!exp_v || (wr_addr === exp_a && wr_data === exp_d));
    checks++;
    if (wr_valid === 1'b1) seen_wr++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d v/e/addr/data act %b %b %h %h exp %b %b %h %h",
               tag, cyc, wr_valid, pkt_err, wr_addr, wr_data, exp_v, exp_e, exp_a, exp_d);
    end
    in_valid = v;
    in_data  = b;
    exp_v = 0; exp_e = 0;
    if (v && in_ready) model_byte(b);
  endtask

  task automatic put_w(input logic [31:0] w);
    bq.push_back(w[31:24]); bq.push_back(w[23:16]);
    bq.push_back(w[15:8]);  bq.push_back(w[7:0]);
  endtask

  task automatic flush();
    while (bq.size() > 0) begin
      if ($urandom_range(0, 3) == 0) tick(0, 8'h00);
      tick(1, bq.pop_front());
    end
    repeat (3) tick(0, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    // R10 reset state; R1 not ready under reset
    chk("R10", wr_valid === 1'b0, "wr_valid in reset", {31'b0, wr_valid}, 0);
    chk("R10", pkt_err === 1'b0, "pkt_err in reset", {31'b0, pkt_err}, 0);
    chk("R1", in_ready === 1'b0, "in_ready in reset", {31'b0, in_ready}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", in_ready === 1'b1, "in_ready after reset", {31'b0, in_ready}, 1);

    // R2: junk, header-like word and partial sync before a misaligned sync
    tag = "R2";
    put_w(32'h30006001); put_w(32'h12345678);
    bq.push_back(8'hAA); bq.push_back(8'h99); bq.push_back(8'h55); bq.push_back(8'h11);
    bq.push_back(8'h01); bq.push_back(8'h02); bq.push_back(8'h03);
    put_w(32'hAA995566);
    flush();

    // R3 R1: type 1 write, two words to register 3, byte order
    tag = "R3";
    put_w(32'h30006002); put_w(32'hDEADBEEF); put_w(32'h01234567);
    flush();

    // R4 R7: zero-count type 1 then type 2; type 2 after a finished type 1 payload
    tag = "R4 R7";
    put_w(32'h3000E000); put_w(32'h50000003);
    put_w(32'hA0000001); put_w(32'hA0000002); put_w(32'hA0000003);
    put_w(32'h30004001); put_w(32'hB0000001);
    put_w(32'h50000002); put_w(32'hB0000002); put_w(32'hB0000003);
    flush();

    // R5 R6: no-op, orphan type 2, type 1 read, no-op
    tag = "R5 R6";
    put_w(32'h20000000); put_w(32'h50000001);
    put_w(32'h20000000); put_w(32'h2800A001); put_w(32'h20000000);
    flush();

    // R8: bad header type, reserved opcode, type 000
    tag = "R8";
    put_w(32'hE0000000); put_w(32'h38000000); put_w(32'h00000000);
    flush();

    // R9: non-desync write to register 4, then desync mid-packet, ignored words, resync
    tag = "R9";
    put_w(32'h30008001); put_w(32'h00000007);
    put_w(32'h30008003); put_w(32'h0000000D); put_w(32'h0000000D);
    put_w(32'h30006001); put_w(32'h11111111);
    bq.push_back(8'h5A);
    put_w(32'hAA995566); put_w(32'h30012001); put_w(32'h00000099);
    flush();

    // R9 R3: total strobes seen: 2 + 6 + 3
    chk("R9", seen_wr == 11, "write strobe total", seen_wr, 11);

    summary();
    $finish;
  end

endmodule